// File: doc/BRIEF.md
# Jump and Call Control Unit

This unit carries out the control-flow instructions of a small 16-bit processor whose register file holds 32 words. The top register is the program counter and the one below it is the stack pointer. A decoder hands the unit the second instruction word and three option bits. The first option bit picks where the target comes from. The second asks for a return address to be saved. The third picks relative or absolute addressing.

The target is either a register, whose index sits in the top five bits of the second word, or the memory word the stack pointer points at. For a call, the return address (program counter plus two) is stored at the stack pointer, and then the stack pointer is decremented by one, so the stack grows downward. Last, the program counter is loaded with the target, or with the old counter plus the target, wrapping at 16 bits. The counter is written once, in the cycle that `done_o` is high.

The controller walks these states: `S_IDLE`, `S_TGT_REQ` (issue the stack read), `S_TGT_WAIT` (wait for the read data), `S_PUSH_REQ` (issue the return-address store), `S_SP_DEC` (write the decremented stack pointer), `S_COMMIT` (write the counter and pulse done). From `S_IDLE`, a start goes to `S_TGT_REQ` when the stack source is chosen. Otherwise it goes to `S_PUSH_REQ` when a push is asked for, and to `S_COMMIT` in all other cases. `S_TGT_REQ` moves on when the request is accepted. `S_TGT_WAIT` moves on when the read data arrives, to `S_PUSH_REQ` or to `S_COMMIT`. `S_PUSH_REQ` moves to `S_SP_DEC` when the request is accepted. `S_SP_DEC` moves to `S_COMMIT`, and `S_COMMIT` moves to `S_IDLE`.

Top module: `jmp_ctl`

## Requirements
- R1: After reset the unit is idle: `done_o`, `busy_o`, `mem_valid_o` and `rf_we_o` are all low.
- R2: With `use_stack_i`=0 the target is the register whose index is `word2_i[15:11]`; the lower eleven bits have no effect. With `rel_i`=0 the new PC equals that target. Index 31 reads the old PC and index 30 reads the old SP.
- R3: With `rel_i`=1 the new PC is the old PC plus the target, modulo 2^16.
- R4: With `use_stack_i`=1 the target is the memory word at the address held in SP, read through one request with `mem_we_o`=0.
- R5: With `push_i`=1 the old PC plus 2 is stored at address SP, and SP then becomes SP-1. The stored value depends only on the PC before the jump, and SP is written only after the store has been accepted.
- R6: `done_o` is high for exactly one cycle per instruction. It coincides with the single register-file write of index 31, which carries the new PC.
- R7: At most one memory request is outstanding. A request held with `mem_ready_i` low keeps its address, direction and data stable.
- R8: A `start_i` seen while `busy_o` is high is ignored and does not change the outcome of the instruction in progress.
- R9: With `push_i`=0, no memory write is made and SP keeps its value.
- R10: With both stack source and push set, the target is read before the return address overwrites the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin an instruction (sampled when idle) |
| word2_i | input | 16 | Second instruction word; bits 15:11 hold the register index |
| use_stack_i | input | 1 | 1: target from memory at SP; 0: target from register |
| push_i | input | 1 | 1: save PC+2 at SP and decrement SP |
| rel_i | input | 1 | 1: relative update; 0: absolute load |
| done_o | output | 1 | One-cycle pulse when the PC write commits |
| busy_o | output | 1 | Instruction in progress |
| rf_ridx_o | output | 5 | Register-file read index |
| rf_rdata_i | input | 16 | Register-file read data |
| pc_i | input | 16 | Current value of register 31 |
| sp_i | input | 16 | Current value of register 30 |
| rf_we_o | output | 1 | Register-file write enable |
| rf_widx_o | output | 5 | Register-file write index |
| rf_wdata_o | output | 16 | Register-file write data |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory request accepted |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 16 | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 16 | Read data |

## Verification
The bench builds the unit with its default parameters: 16-bit words, 32 registers and a return offset of 2. The 16-bit width lets a relative add starting just below 0xFFFF wrap past zero, and lets a target of 0xFFFE act as a backward step of two. With 32 registers, indices 30 and 31 can be chosen as targets, so the bench reaches the cases where the target is the stack pointer or the counter itself. Every vector runs once with a memory that is always ready and once with a memory that stalls every other cycle. The stalled run holds requests open and gives time to fire start pulses while the unit is busy.

// File: rtl/jmp_ctl_pkg.sv
package jmp_ctl_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_TGT_REQ,
        S_TGT_WAIT,
        S_PUSH_REQ,
        S_SP_DEC,
        S_COMMIT
    } jc_state_e;
endpackage

// File: rtl/jmp_ctl_pc_next.sv
module jmp_ctl_pc_next #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] pc_old,
    input  logic [DATA_W-1:0] target,
    input  logic              relative,
    output logic [DATA_W-1:0] pc_new
);
    logic [DATA_W-1:0] sum;

    assign sum    = pc_old + target;
    assign pc_new = relative ? sum : target;
endmodule

// File: rtl/jmp_ctl_stack_calc.sv
module jmp_ctl_stack_calc #(
    parameter int DATA_W  = 16,
    parameter int RET_OFS = 2
) (
    input  logic [DATA_W-1:0] pc_old,
    input  logic [DATA_W-1:0] sp_old,
    output logic [DATA_W-1:0] ret_addr,
    output logic [DATA_W-1:0] sp_down
);
    localparam logic [DATA_W-1:0] OFS = DATA_W'(RET_OFS);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    assign ret_addr = pc_old + OFS;
    assign sp_down  = sp_old - ONE;
endmodule

// File: rtl/jmp_ctl.sv
module jmp_ctl
    import jmp_ctl_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int REG_CNT = 32,
    parameter int RET_OFS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [DATA_W-1:0]          word2_i,
    input  logic                       use_stack_i,
    input  logic                       push_i,
    input  logic                       rel_i,
    output logic                       done_o,
    output logic                       busy_o,
    output logic [$clog2(REG_CNT)-1:0] rf_ridx_o,
    input  logic [DATA_W-1:0]          rf_rdata_i,
    input  logic [DATA_W-1:0]          pc_i,
    input  logic [DATA_W-1:0]          sp_i,
    output logic                       rf_we_o,
    output logic [$clog2(REG_CNT)-1:0] rf_widx_o,
    output logic [DATA_W-1:0]          rf_wdata_o,
    output logic                       mem_valid_o,
    input  logic                       mem_ready_i,
    output logic                       mem_we_o,
    output logic [DATA_W-1:0]          mem_addr_o,
    output logic [DATA_W-1:0]          mem_wdata_o,
    input  logic                       mem_rvalid_i,
    input  logic [DATA_W-1:0]          mem_rdata_i
);
    localparam int                IDX_W  = $clog2(REG_CNT);
    localparam logic [IDX_W-1:0]  PC_IDX = IDX_W'(REG_CNT - 1);
    localparam logic [IDX_W-1:0]  SP_IDX = IDX_W'(REG_CNT - 2);

    jc_state_e         state_q, state_d;
    logic [DATA_W-1:0] pc_q, sp_q, tgt_q;
    logic              push_q, rel_q;
    logic [DATA_W-1:0] pc_new, ret_addr, sp_down;

    assign rf_ridx_o = word2_i[DATA_W-1 -: IDX_W];

    jmp_ctl_pc_next #(.DATA_W(DATA_W)) u_pc_next (
        .pc_old   (pc_q),
        .target   (tgt_q),
        .relative (rel_q),
        .pc_new   (pc_new)
    );

    jmp_ctl_stack_calc #(.DATA_W(DATA_W), .RET_OFS(RET_OFS)) u_stack_calc (
        .pc_old   (pc_q),
        .sp_old   (sp_q),
        .ret_addr (ret_addr),
        .sp_down  (sp_down)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    if (use_stack_i)  state_d = S_TGT_REQ;
                    else if (push_i)  state_d = S_PUSH_REQ;
                    else              state_d = S_COMMIT;
                end
            end
            S_TGT_REQ:  if (mem_ready_i) state_d = S_TGT_WAIT;
            S_TGT_WAIT: if (mem_rvalid_i) state_d = push_q ? S_PUSH_REQ : S_COMMIT;
            S_PUSH_REQ: if (mem_ready_i) state_d = S_SP_DEC;
            S_SP_DEC:   state_d = S_COMMIT;
            S_COMMIT:   state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register and captured operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pc_q    <= '0;
            sp_q    <= '0;
            tgt_q   <= '0;
            push_q  <= 1'b0;
            rel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start_i) begin
                pc_q   <= pc_i;
                sp_q   <= sp_i;
                tgt_q  <= rf_rdata_i;
                push_q <= push_i;
                rel_q  <= rel_i;
            end
            if (state_q == S_TGT_WAIT && mem_rvalid_i) begin
                tgt_q <= mem_rdata_i;
            end
        end
    end

    // outputs
    always_comb begin
        done_o      = 1'b0;
        busy_o      = (state_q != S_IDLE);
        rf_we_o     = 1'b0;
        rf_widx_o   = PC_IDX;
        rf_wdata_o  = pc_new;
        mem_valid_o = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = sp_q;
        mem_wdata_o = ret_addr;
        unique case (state_q)
            S_IDLE, S_TGT_WAIT: ;
            S_TGT_REQ:  mem_valid_o = 1'b1;
            S_PUSH_REQ: begin
                mem_valid_o = 1'b1;
                mem_we_o    = 1'b1;
            end
            S_SP_DEC: begin
                rf_we_o    = 1'b1;
                rf_widx_o  = SP_IDX;
                rf_wdata_o = sp_down;
            end
            S_COMMIT: begin
                rf_we_o = 1'b1;
                done_o  = 1'b1;
            end
            default: ;
        endcase
    end

    // R1: idle means no traffic on either port
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_valid_o && !rf_we_o && !done_o));

    // R6: done lasts a single cycle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: done marks the PC write
    p_done_pc_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rf_we_o && rf_widx_o == PC_IDX));

    // R7: a stalled request stays stable
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_ready_i) |=>
            (mem_valid_o && $stable(mem_we_o) && $stable(mem_addr_o) && $stable(mem_wdata_o)));

    // R7: no new request while read data is pending
    p_one_outstanding_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TGT_WAIT) |-> !mem_valid_o);

    // R5: SP is written only right after an accepted store
    p_sp_after_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && rf_widx_o == SP_IDX) |-> $past(mem_valid_o && mem_ready_i && mem_we_o));
endmodule

// File: tb/test_jmp_ctl.sv
`timescale 1ns/1ps
module test_jmp_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] word2_i = '0;
    logic        use_stack_i = 1'b0, push_i = 1'b0, rel_i = 1'b0;
    logic        done_o, busy_o, rf_we_o, mem_valid_o, mem_we_o;
    logic [4:0]  rf_ridx_o, rf_widx_o;
    logic [15:0] rf_rdata_i, pc_i, sp_i, rf_wdata_o, mem_addr_o, mem_wdata_o;
    logic        mem_ready_i, mem_rvalid_i = 1'b0;
    logic [15:0] mem_rdata_i = '0;

    logic [15:0] rf  [32];
    logic [15:0] mem [256];
    logic        slow = 1'b0;
    logic        gap  = 1'b0;
    int          wr_cnt = 0;
    logic        pre_en = 1'b0;
    logic [4:0]  pre_idx = '0;
    logic [15:0] pre_pc = '0, pre_sp = '0, pre_rv = '0, pre_sw = '0;

    int errs = 0;
    int total = 0;

    always #4 clk = ~clk;

    assign pc_i        = rf[31];
    assign sp_i        = rf[30];
    assign rf_rdata_i  = rf[rf_ridx_o];
    assign mem_ready_i = slow ? gap : 1'b1;

    jmp_ctl i_jmp_ctl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .word2_i(word2_i),
        .use_stack_i(use_stack_i), .push_i(push_i), .rel_i(rel_i),
        .done_o(done_o), .busy_o(busy_o), .rf_ridx_o(rf_ridx_o),
        .rf_rdata_i(rf_rdata_i), .pc_i(pc_i), .sp_i(sp_i),
        .rf_we_o(rf_we_o), .rf_widx_o(rf_widx_o), .rf_wdata_o(rf_wdata_o),
        .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
    );

    // register file and memory models
    always @(posedge clk) begin
        gap <= ~gap;
        mem_rvalid_i <= 1'b0;
        if (pre_en) begin
            rf[pre_idx]       <= pre_rv;
            rf[31]            <= pre_pc;
            rf[30]            <= pre_sp;
            mem[pre_sp[7:0]]  <= pre_sw;
            wr_cnt            <= 0;
        end else begin
            if (rf_we_o) rf[rf_widx_o] <= rf_wdata_o;
            if (mem_valid_o && mem_ready_i) begin
                if (mem_we_o) begin
                    mem[mem_addr_o[7:0]] <= mem_wdata_o;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    mem_rvalid_i <= 1'b1;
                    mem_rdata_i  <= mem[mem_addr_o[7:0]];
                end
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            errs++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // {idx, stack, push, rel, pc0, sp0, reg value, stack word}
    localparam logic [71:0] VEC [9] = '{
        {5'd5,  1'b0, 1'b0, 1'b0, 16'h0100, 16'h00F0, 16'h1234, 16'h0000},
        {5'd7,  1'b0, 1'b0, 1'b1, 16'h0200, 16'h00F0, 16'h0010, 16'h0000},
        {5'd3,  1'b0, 1'b0, 1'b1, 16'hFFF0, 16'h00F0, 16'h0020, 16'h0000},
        {5'd9,  1'b0, 1'b0, 1'b1, 16'h0100, 16'h00F0, 16'hFFFE, 16'h0000},
        {5'd0,  1'b1, 1'b0, 1'b0, 16'h0300, 16'h0080, 16'h5555, 16'h0ABC},
        {5'd12, 1'b0, 1'b1, 1'b0, 16'h0400, 16'h0070, 16'h0800, 16'h1111},
        {5'd0,  1'b1, 1'b1, 1'b1, 16'hFFFC, 16'h0060, 16'h0000, 16'h0008},
        {5'd31, 1'b0, 1'b0, 1'b1, 16'h0123, 16'h00F0, 16'h0000, 16'h0000},
        {5'd30, 1'b0, 1'b1, 1'b0, 16'h0500, 16'h0050, 16'h0000, 16'h0000}
    };

    task automatic preset(input logic [4:0] idx, input logic [15:0] pc0, sp0, rv, sw);
        @(negedge clk);
        pre_en = 1'b1; pre_idx = idx; pre_pc = pc0; pre_sp = sp0; pre_rv = rv; pre_sw = sw;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    task automatic issue(input logic [4:0] idx, input logic st, pu, re);
        @(negedge clk);
        start_i = 1'b1; word2_i = {idx, 11'h5A5};
        use_stack_i = st; push_i = pu; rel_i = re;
        @(negedge clk);
        start_i = 1'b0; word2_i = 16'hFFFF;
        use_stack_i = 1'b0; push_i = 1'b0; rel_i = 1'b0;
    endtask

    // wait for done; sample one negedge later, after the PC write
    task automatic wait_done(input string tag);
        int n = 0;
        while (!done_o && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(done_o, {tag, " R6 done seen"}, 16'(done_o), 16'd1);
        @(negedge clk);
        chk(!done_o, {tag, " R6 done one cycle"}, 16'(done_o), 16'd0);
    endtask

    task automatic run_vec(input logic [71:0] v, input string tag);
        logic [4:0]  idx = v[71:67];
        logic        st = v[66], pu = v[65], re = v[64];
        logic [15:0] pc0 = v[63:48], sp0 = v[47:32], rv = v[31:16], sw = v[15:0];
        logic [15:0] tgt, epc, esp, emem;
        if (st)               tgt = sw;
        else if (idx == 5'd31) tgt = pc0;
        else if (idx == 5'd30) tgt = sp0;
        else                  tgt = rv;
        epc  = re ? 16'(pc0 + tgt) : tgt;
        esp  = pu ? 16'(sp0 - 16'd1) : sp0;
        emem = pu ? 16'(pc0 + 16'd2) : sw;
        preset(idx, pc0, sp0, rv, sw);
        issue(idx, st, pu, re);
        wait_done(tag);
        chk(rf[31] == epc, {tag, " R2 R3 R4 R10 new PC"}, rf[31], epc);
        chk(rf[30] == esp, {tag, " R5 R9 SP"}, rf[30], esp);
        chk(mem[sp0[7:0]] == emem, {tag, " R5 R10 stack word"}, mem[sp0[7:0]], emem);
        chk(wr_cnt == (pu ? 1 : 0), {tag, " R9 write count"}, 16'(wr_cnt), 16'(pu ? 1 : 0));
    endtask

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = 16'h0;
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!done_o && !busy_o && !mem_valid_o && !rf_we_o, "R1 in reset",
            {12'h0, done_o, busy_o, mem_valid_o, rf_we_o}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done_o && !busy_o && !mem_valid_o && !rf_we_o, "R1 after reset",
            {12'h0, done_o, busy_o, mem_valid_o, rf_we_o}, 16'h0);

        for (int pass = 0; pass < 2; pass++) begin
            slow = (pass == 1);
            for (int k = 0; k < 9; k++)
                run_vec(VEC[k], $sformatf("vec%0d pass%0d", k, pass));
        end

        // R8: start pulses while busy are ignored
        slow = 1'b1;
        preset(5'd12, 16'h0400, 16'h0070, 16'h0800, 16'h1111);
        issue(5'd12, 1'b0, 1'b1, 1'b0);
        chk(busy_o, "R8 busy during call", 16'(busy_o), 16'd1);
        start_i = 1'b1; word2_i = {5'd7, 11'h0}; rel_i = 1'b1; use_stack_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; rel_i = 1'b0; use_stack_i = 1'b0;
        wait_done("R8 busy start");
        chk(rf[31] == 16'h0800, "R8 PC unaffected by extra start", rf[31], 16'h0800);
        chk(rf[30] == 16'h006F, "R8 SP after call", rf[30], 16'h006F);
        chk(mem[8'h70] == 16'h0402, "R8 return address", mem[8'h70], 16'h0402);
        repeat (6) @(negedge clk);
        chk(!busy_o, "R8 no second instruction", 16'(busy_o), 16'd0);

        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        total++;
        $display("FAIL watchdog act=%h exp=%h", 16'd1, 16'd0);
        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end
endmodule